// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage Pipeline

This block tracks exceptions in a fetch, decode, execute, memory and writeback pipeline so that they are taken in program order. The fetch, decode, execute and memory stages each have a request line. An accepted request sets a mark in the pipeline register to the right of the stage that raised it. The mark then moves down the pipeline with its instruction, one register per cycle, together with the instruction's PC and a cause code. Writeback never raises a request.

The block keeps its own fetch PC. Each stage gets a squash line that tells it to hold its control lines at no-op values, and the fetch stage is halted as soon as any request is accepted. A marked instruction commits its exception when it reaches the MEM/WB register. At that point the block captures that instruction's PC and cause, pulses a taken strobe, and discards every younger instruction still in flight. Older instructions retire untouched. A resume input restarts fetch at a supplied address once the handler has run.

Top module: `exc_tracker`

## Requirements
- R1: After reset the fetch PC equals the RESET_PC parameter (default 0x100), fetchHalt is 0, excTaken is 0, excPc is 0, excCause is 0, and all four squash bits are 1, because the pipeline registers are empty.
- R2: While fetchHalt is 0, the fetch PC advances by PC_STEP (default 4) on every clock edge.
- R3: A request on excReq bit k is taken when the stage holds a valid instruction that is not yet marked. Bit 0 is fetch, 1 is decode, 2 is execute and 3 is memory. For a taken request, excTaken pulses exactly 5-k clock edges after the edge at which the request was sampled.
- R4: When excTaken is 1, excPc holds the PC of the instruction that was marked, and excCause holds the code of the stage that marked it: 1 fetch, 2 decode, 3 execute, 4 memory.
- R5: fetchHalt becomes 1 on the edge after a request is taken. The fetch PC holds its value while fetchHalt is 1 and resume is 0.
- R6: squash bit 0 covers decode, bit 1 execute, bit 2 memory and bit 3 writeback. A bit is 1 when the pipeline register feeding that stage holds a marked instruction or a bubble, and 0 for a valid unmarked instruction.
- R7: In the cycle a marked instruction sits in MEM/WB, all squash bits are 1. On the next edge every younger instruction is discarded, so it raises no further excTaken.
- R8: If a younger instruction is marked before an older one, the older one's exception is the one taken. Only one excTaken pulse results.
- R9: Once an instruction is marked, later requests against it leave its cause unchanged, so the earliest detecting stage is reported.
- R10: Requests on stages that hold no valid instruction are ignored: they produce no excTaken pulse and leave excPc unchanged.
- R11: When resume is 1 while fetch is halted, fetchHalt clears on the next edge and the fetch PC is loaded with resumePc. From then on it advances normally.
- R12: excTaken is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| excReq | input | 4 | Per-stage exception requests: bit 0 fetch, 1 decode, 2 execute, 3 memory |
| resume | input | 1 | Restart fetch after the handler |
| resumePc | input | PC_W | Restart address loaded on resume |
| fetchPc | output | PC_W | PC of the instruction being fetched |
| fetchHalt | output | 1 | Fetch stopped |
| squash | output | 4 | No-op controls for decode, execute, memory and writeback |
| excTaken | output | 1 | One-cycle pulse when an exception commits |
| excPc | output | PC_W | PC of the committed faulting instruction |
| excCause | output | 3 | Cause code of the committed exception |

## Verification
Separate runs raise a single request at each of the four stages. This separates the commit latency per stage and checks that the captured PC is the instruction's own PC and not the fetch PC. A run with a decode request followed by a memory request on an older instruction shows that commit follows program order rather than detection order. A run with repeated requests on the same instruction shows that the first cause is kept. Requests raised on an emptied pipeline show that bubbles cannot fault. A resume afterwards shows the restart address being loaded and fetch running again.

// File: rtl/exc_track_pkg.sv
package exc_track_pkg;

  localparam int unsigned DETECT_STAGES = 4;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_FETCH  = 3'd1,
    CAUSE_DECODE = 3'd2,
    CAUSE_EXEC   = 3'd3,
    CAUSE_MEM    = 3'd4
  } cause_e;

  typedef struct packed {
    logic [DETECT_STAGES-1:0] setFlag;
    logic                     flush;
    logic                     commit;
    logic                     advance;
    logic                     loadResume;
  } ctrl_strobe_t;

  function automatic cause_e stageCause(input int unsigned idx);
    case (idx)
      0:       return CAUSE_FETCH;
      1:       return CAUSE_DECODE;
      2:       return CAUSE_EXEC;
      default: return CAUSE_MEM;
    endcase
  endfunction

endpackage

// File: rtl/exc_track_datapath.sv
module exc_track_datapath
  import exc_track_pkg::*;
#(
  parameter int unsigned     PC_W     = 32,
  parameter int unsigned     PC_STEP  = 4,
  parameter logic [PC_W-1:0] RESET_PC = 'h100
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrl_strobe_t             strobe,
  input  logic [PC_W-1:0]          resumePc,
  output logic [DETECT_STAGES-1:0] regValid,
  output logic [DETECT_STAGES-1:0] regFlag,
  output logic [PC_W-1:0]          fetchPc,
  output logic                     excTaken,
  output logic [PC_W-1:0]          excPc,
  output logic [2:0]               excCause
);

  localparam int unsigned NREG = DETECT_STAGES;
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  logic            vldQ   [NREG];
  logic            flgQ   [NREG];
  cause_e          causeQ [NREG];
  logic [PC_W-1:0] pcQ    [NREG];

  logic            nVld   [NREG];
  logic            nFlg   [NREG];
  cause_e          nCause [NREG];
  logic [PC_W-1:0] nPc    [NREG];

  logic [PC_W-1:0] fetchPcQ;
  logic [PC_W-1:0] excPcQ;
  cause_e          excCauseQ;
  logic            takenQ;

  // next-state of each pipeline register: IF/ID, ID/EX, EX/MEM, MEM/WB
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    if (k == 0) begin : g_head
      assign nVld[k]   = strobe.advance & ~strobe.flush;
      assign nFlg[k]   = strobe.setFlag[k] & nVld[k];
      assign nCause[k] = strobe.setFlag[k] ? stageCause(k) : CAUSE_NONE;
      assign nPc[k]    = fetchPcQ;
    end else begin : g_body
      assign nVld[k]   = vldQ[k-1] & ~strobe.flush;
      assign nFlg[k]   = (flgQ[k-1] | strobe.setFlag[k]) & nVld[k];
      assign nCause[k] = flgQ[k-1]          ? causeQ[k-1]   :
                         strobe.setFlag[k]  ? stageCause(k) : CAUSE_NONE;
      assign nPc[k]    = pcQ[k-1];
    end
    assign regValid[k] = vldQ[k];
    assign regFlag[k]  = flgQ[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        vldQ[i]   <= 1'b0;
        flgQ[i]   <= 1'b0;
        causeQ[i] <= CAUSE_NONE;
        pcQ[i]    <= '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        vldQ[i]   <= nVld[i];
        flgQ[i]   <= nFlg[i];
        causeQ[i] <= nCause[i];
        pcQ[i]    <= nPc[i];
      end
    end
  end

  // fetch PC: restart load wins over sequential advance
  always_ff @(posedge clk) begin
    if (rst) begin
      fetchPcQ <= RESET_PC;
    end else if (strobe.loadResume) begin
      fetchPcQ <= resumePc;
    end else if (strobe.advance) begin
      fetchPcQ <= fetchPcQ + STEP;
    end
  end

  // exception record, captured from MEM/WB on commit
  always_ff @(posedge clk) begin
    if (rst) begin
      excPcQ    <= '0;
      excCauseQ <= CAUSE_NONE;
      takenQ    <= 1'b0;
    end else begin
      takenQ <= strobe.commit;
      if (strobe.commit) begin
        excPcQ    <= pcQ[NREG-1];
        excCauseQ <= causeQ[NREG-1];
      end
    end
  end

  assign fetchPc  = fetchPcQ;
  assign excTaken = takenQ;
  assign excPc    = excPcQ;
  assign excCause = excCauseQ;

endmodule

// File: rtl/exc_track_control.sv
module exc_track_control
  import exc_track_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DETECT_STAGES-1:0] excReq,
  input  logic                     resume,
  input  logic [DETECT_STAGES-1:0] regValid,
  input  logic [DETECT_STAGES-1:0] regFlag,
  output ctrl_strobe_t             strobe,
  output logic                     fetchHalt,
  output logic [DETECT_STAGES-1:0] squash
);

  localparam int unsigned NREG = DETECT_STAGES;

  logic            haltQ;
  logic [NREG-1:0] stageValid;
  logic [NREG-1:0] stageFlag;
  logic [NREG-1:0] setFlag;
  logic            commit;
  logic            anyNew;

  // stage k works on the contents of register k-1; fetch is valid unless halted
  assign stageValid = {regValid[NREG-2:0], ~haltQ};
  assign stageFlag  = {regFlag[NREG-2:0], 1'b0};
  assign commit     = regValid[NREG-1] & regFlag[NREG-1];

  for (genvar k = 0; k < NREG; k++) begin : g_accept
    assign setFlag[k] = excReq[k] & stageValid[k] & ~stageFlag[k] & ~commit;
    assign squash[k]  = ~regValid[k] | regFlag[k] | commit;
  end

  assign anyNew = |setFlag;

  always_ff @(posedge clk) begin
    if (rst) begin
      haltQ <= 1'b0;
    end else if (commit || anyNew) begin
      haltQ <= 1'b1;
    end else if (resume) begin
      haltQ <= 1'b0;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.setFlag    = setFlag;
    strobe.flush      = commit;
    strobe.commit     = commit;
    strobe.advance    = ~haltQ;
    strobe.loadResume = resume & haltQ & ~anyNew & ~commit;
  end

  assign fetchHalt = haltQ;

endmodule

// File: rtl/exc_tracker.sv
module exc_tracker
  import exc_track_pkg::*;
#(
  parameter int unsigned     PC_W     = 32,
  parameter int unsigned     PC_STEP  = 4,
  parameter logic [PC_W-1:0] RESET_PC = 'h100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      excReq,
  input  logic            resume,
  input  logic [PC_W-1:0] resumePc,
  output logic [PC_W-1:0] fetchPc,
  output logic            fetchHalt,
  output logic [3:0]      squash,
  output logic            excTaken,
  output logic [PC_W-1:0] excPc,
  output logic [2:0]      excCause
);

  ctrl_strobe_t             strobe;
  logic [DETECT_STAGES-1:0] regValid;
  logic [DETECT_STAGES-1:0] regFlag;

  exc_track_control u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .excReq    (excReq),
    .resume    (resume),
    .regValid  (regValid),
    .regFlag   (regFlag),
    .strobe    (strobe),
    .fetchHalt (fetchHalt),
    .squash    (squash)
  );

  exc_track_datapath #(
    .PC_W     (PC_W),
    .PC_STEP  (PC_STEP),
    .RESET_PC (RESET_PC)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .resumePc (resumePc),
    .regValid (regValid),
    .regFlag  (regFlag),
    .fetchPc  (fetchPc),
    .excTaken (excTaken),
    .excPc    (excPc),
    .excCause (excCause)
  );

endmodule

// File: rtl/exc_tracker_checker.sv
module exc_tracker_checker #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned PC_STEP = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            resume,
  input logic [PC_W-1:0] resumePc,
  input logic [PC_W-1:0] fetchPc,
  input logic            fetchHalt,
  input logic [3:0]      squash,
  input logic            excTaken,
  input logic [2:0]      excCause
);

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
    !fetchHalt |=> fetchPc == $past(fetchPc) + PC_W'(PC_STEP));

  p_cause_range_r4: assert property (@(posedge clk) disable iff (rst)
    excTaken |-> (excCause >= 3'd1 && excCause <= 3'd4));

  p_halt_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (fetchHalt && !resume) |=> ($stable(fetchPc) && fetchHalt));

  p_commit_squash_r7: assert property (@(posedge clk) disable iff (rst)
    excTaken |-> ($past(squash) == 4'hF && fetchHalt));

  p_resume_load_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(fetchHalt) |-> fetchPc == $past(resumePc));

  p_single_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    excTaken |=> !excTaken);

endmodule

bind exc_tracker exc_tracker_checker #(
  .PC_W    (PC_W),
  .PC_STEP (PC_STEP)
) u_checker (
  .clk       (clk),
  .rst       (rst),
  .resume    (resume),
  .resumePc  (resumePc),
  .fetchPc   (fetchPc),
  .fetchHalt (fetchHalt),
  .squash    (squash),
  .excTaken  (excTaken),
  .excCause  (excCause)
);

// File: tb/tb_exc_tracker.sv
`timescale 1ns/1ps
module tb_exc_tracker;

  localparam int unsigned PC_W = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic [3:0]      excReq;
  logic            resume;
  logic [PC_W-1:0] resumePc;
  logic [PC_W-1:0] fetchPc;
  logic            fetchHalt;
  logic [3:0]      squash;
  logic            excTaken;
  logic [PC_W-1:0] excPc;
  logic [2:0]      excCause;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  exc_tracker dut (
    .clk       (clk),
    .rst       (rst),
    .excReq    (excReq),
    .resume    (resume),
    .resumePc  (resumePc),
    .fetchPc   (fetchPc),
    .fetchHalt (fetchHalt),
    .squash    (squash),
    .excTaken  (excTaken),
    .excPc     (excPc),
    .excCause  (excCause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1; excReq = '0; resume = 1'b0; resumePc = '0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  // wait for the taken pulse; returns edges counted since the last request edge
  task automatic waitTaken(input int startEdges, output int edges);
    edges = startEdges;
    while (!excTaken && edges < 20) begin
      tick();
      edges++;
    end
  endtask

  task automatic testReset();
    doReset();
    chk("R1 fetchPc", fetchPc, 32'h100);
    chk("R1 fetchHalt", 32'(fetchHalt), 0);
    chk("R1 excTaken", 32'(excTaken), 0);
    chk("R1 excPc", excPc, 0);
    chk("R1 excCause", 32'(excCause), 0);
    chk("R1 squash", 32'(squash), 32'hF);
    repeat (3) tick();
    chk("R2 fetch advance", fetchPc, 32'h10C);
    repeat (3) tick();
    chk("R6 squash full pipe", 32'(squash), 0);
  endtask

  task automatic testSingle(input int k);
    logic [31:0] f;
    int n;
    doReset();
    repeat (6) tick();
    f = fetchPc;
    excReq = 4'(1 << k);
    tick();
    excReq = '0;
    chk($sformatf("R5 halt stage%0d", k), 32'(fetchHalt), 1);
    waitTaken(1, n);
    chk($sformatf("R3 latency stage%0d", k), n, 5 - k);
    chk($sformatf("R4 excPc stage%0d", k), excPc, f - 32'(4 * k));
    chk($sformatf("R4 cause stage%0d", k), 32'(excCause), k + 1);
    chk($sformatf("R7 squash after commit stage%0d", k), 32'(squash), 32'hF);
    tick();
    chk($sformatf("R12 pulse stage%0d", k), 32'(excTaken), 0);
    chk($sformatf("R5 pc hold stage%0d", k), fetchPc, f + 4);
  endtask

  task automatic testSquash();
    int pulses;
    doReset();
    repeat (6) tick();
    excReq = 4'b0100;
    tick();
    excReq = '0;
    chk("R6 squash marked in memory", 32'(squash), 32'h4);
    tick();
    chk("R7 squash commit cycle", 32'(squash), 32'hF);
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (excTaken) pulses++;
    end
    chk("R7 younger discarded", pulses, 1);
  endtask

  task automatic testOrder();
    logic [31:0] f;
    logic [31:0] capPc;
    logic [2:0]  capCause;
    int pulses;
    doReset();
    repeat (6) tick();
    f = fetchPc;
    excReq = 4'b0010;
    tick();
    excReq = 4'b1000;
    tick();
    excReq = '0;
    pulses = 0; capPc = '0; capCause = '0;
    for (int i = 0; i < 10; i++) begin
      if (excTaken) begin
        pulses++;
        capPc = excPc;
        capCause = excCause;
      end
      tick();
    end
    chk("R8 one pulse", pulses, 1);
    chk("R8 older pc", capPc, f - 8);
    chk("R8 older cause", 32'(capCause), 4);
  endtask

  task automatic testFirstCause();
    logic [31:0] f;
    int n;
    doReset();
    repeat (6) tick();
    f = fetchPc;
    excReq = 4'b0001;
    tick();
    excReq = 4'b0010;
    tick();
    excReq = 4'b0100;
    tick();
    excReq = '0;
    waitTaken(3, n);
    chk("R9 latency", n, 5);
    chk("R9 pc", excPc, f);
    chk("R9 first cause kept", 32'(excCause), 1);
  endtask

  task automatic testIgnoreAndResume();
    logic [31:0] held;
    int pulses;
    testSingle(2);
    held = excPc;
    repeat (2) tick();
    pulses = 0;
    excReq = 4'hF;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (excTaken) pulses++;
    end
    excReq = '0;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (excTaken) pulses++;
    end
    chk("R10 no pulse on bubbles", pulses, 0);
    chk("R10 excPc unchanged", excPc, held);
    resumePc = 32'h2000;
    resume = 1'b1;
    tick();
    resume = 1'b0;
    chk("R11 halt cleared", 32'(fetchHalt), 0);
    chk("R11 pc loaded", fetchPc, 32'h2000);
    tick();
    chk("R11 pc advances", fetchPc, 32'h2004);
    repeat (4) tick();
    chk("R11 pipeline refilled", 32'(squash), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; excReq = '0; resume = 1'b0; resumePc = '0;
    testReset();
    for (int k = 0; k < 4; k++) testSingle(k);
    testSquash();
    testOrder();
    testFirstCause();
    testIgnoreAndResume();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule